// File: doc/BRIEF.md
# Spectrum Bin Averaging Scaler

This block turns a stream of squared-magnitude spectrum samples into bar heights for one graph of a spectrum display. It groups incoming samples into bins of six and sums each bin. It then scales the sum to a height between 0 and 72 pixels. No divider and no multiplier are used: the sum is tripled with one shift-add, and the result is truncated. Eight consecutive heights form one display column. They are written into one page of a small two-page buffer, and the two pages alternate so that one page can fill while a renderer reads the other.

When a page is full, the block raises a one-cycle `run` pulse for the downstream column renderer. The pulse carries the page to read, the display column number and the sender id of the data. A frame covers display columns 2 through 22 (21 pages of eight bins, 1008 samples). The 16 samples that follow are taken and thrown away, and the block then goes idle until the next `start`. The renderer reads the buffer through an independent read port.

Samples arrive on a valid/ready stream. While `smp_valid` is high and `smp_ready` is low, the source must hold `smp_data` and `smp_sender` steady. A sample is taken on a rising edge where both are high. After each transfer the block keeps `smp_ready` low until it has seen `smp_valid` low for at least one cycle. Each sample must therefore be followed by a drop of `smp_valid`. The `run` output has no back-pressure.

Top module: `spec_bin_scaler`

## Requirements
- R1: After reset, `smp_ready` and `run` are low and every buffer entry reads 0.
- R2: While idle, `smp_ready` stays low whatever `smp_valid` does. A cycle with `start` high moves the block into a frame, beginning at column 2 and bin index 0.
- R3: A sample is taken only on an edge where `smp_valid` and `smp_ready` are both high. In the cycle after a transfer, `smp_ready` is low, and it stays low until `smp_valid` has been low for a cycle.
- R4: Every six accepted samples of a frame form one bin. The `run_sender` reported for a page is the `smp_sender` of the last sample accepted before that page closed.
- R5: A bin's height is bits [21:15] of three times its 20-bit sum, limited to at most 72.
- R6: A height is written at buffer address {page, index}. Bit 3 is the page, and bits [2:0] are the bin order within the page, 0 for the oldest and 7 for the newest. `rd_data` shows the entry at `rd_addr` combinationally.
- R7: After the eighth bin of a page is written, `run` is high for exactly one cycle, with `run_page` equal to the page just filled. The next page used is the other one, and the page bit carries over from frame to frame.
- R8: `run_col` is 2 on the first page of a frame and rises by one on each page, up to 22. A frame therefore gives 21 pulses.
- R9: After the column 22 pulse, the next 16 samples are accepted, change no buffer entry and raise no pulse. The block then returns to idle.
- R10: The bin sum starts from zero for every bin, so a bin's height depends only on its own six samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a frame when the block is idle |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready |
| smp_data | input | 17 | Squared-magnitude sample |
| smp_sender | input | 2 | Id of the party sending the sample |
| rd_addr | input | 4 | Buffer read address {page, index} |
| rd_data | output | 8 | Buffer read data (height) |
| run | output | 1 | One-cycle pulse: a page is ready |
| run_page | output | 1 | Page to render |
| run_col | output | 5 | Display column of that page |
| run_sender | output | 2 | Sender id of that page |

## Verification
The first page uses uniform bins whose values step across the scaler's range: zero, a single count, points just below and just above an integer height, and the full-scale value. These show whether the shift-add and the truncation land on the correct side of each step. The remaining columns use a distinct ramp in every bin, so a swapped index, a stale page or a wrong column count changes the values read back. Trailing samples at full scale after column 22 reveal any write or pulse that the discard window lets through. A second frame begins with a non-uniform bin, which shows whether the sum was cleared and whether the page bit carries over.

// File: rtl/sbas_pkg.sv
package sbas_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_TAKE  = 2'd1,
    PH_WRITE = 2'd2,
    PH_DROP  = 2'd3
  } phase_t;
endpackage

// File: rtl/sbas_bin_acc.sv
module sbas_bin_acc #(
  parameter int SAMPLE_W = 17,
  parameter int SUM_W    = 20,
  parameter int ID_W     = 2,
  parameter int BIN_LEN  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                add_en,
  input  logic                clr,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic [ID_W-1:0]     smp_id,
  output logic [SUM_W-1:0]    sum,
  output logic [ID_W-1:0]     sender,
  output logic                bin_last
);
  localparam int CNT_W = $clog2(BIN_LEN + 1);

  logic [CNT_W-1:0] cnt;

  // the sample being added now closes the bin
  assign bin_last = (cnt == CNT_W'(BIN_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum    <= '0;
      cnt    <= '0;
      sender <= '0;
    end else if (clr) begin
      sum <= '0;
      cnt <= '0;
    end else if (add_en) begin
      sum    <= sum + SUM_W'(smp);
      cnt    <= cnt + 1'b1;
      sender <= smp_id;
    end
  end
endmodule

// File: rtl/sbas_height_scale.sv
module sbas_height_scale #(
  parameter int SUM_W      = 20,
  parameter int TRUNC_LSB  = 15,
  parameter int HEIGHT_W   = 8,
  parameter int HEIGHT_MAX = 72
) (
  input  logic [SUM_W-1:0]    sum,
  output logic [HEIGHT_W-1:0] height
);
  localparam int PROD_W  = SUM_W + 2;
  localparam int FIELD_W = PROD_W - TRUNC_LSB;

  logic [PROD_W-1:0]  prod;
  logic [FIELD_W-1:0] field;

  // times three as sum + 2*sum; averaging by six and scaling share this step
  assign prod  = {2'b00, sum} + {1'b0, sum, 1'b0};
  assign field = FIELD_W'(prod >> TRUNC_LSB);

  always_comb begin
    if (HEIGHT_W'(field) > HEIGHT_W'(HEIGHT_MAX)) height = HEIGHT_W'(HEIGHT_MAX);
    else                                          height = HEIGHT_W'(field);
  end
endmodule

// File: rtl/sbas_page_buf.sv
module sbas_page_buf #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ent [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(e))     q <= wr_data;
    end
    assign ent[e] = q;
  end

  assign rd_data = ent[rd_addr];
endmodule

// File: rtl/sbas_frame_ctrl.sv
module sbas_frame_ctrl
  import sbas_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int ID_W      = 2,
  parameter int COL_W     = 5,
  parameter int COL_FIRST = 2,
  parameter int COL_LAST  = 22,
  parameter int SKIP_LEN  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic             bin_last,
  input  logic [ID_W-1:0]  sender,
  output logic             acc_add,
  output logic             acc_clr,
  output logic             buf_we,
  output logic [IDX_W:0]   buf_waddr,
  output logic             run,
  output logic             run_page,
  output logic [COL_W-1:0] run_col,
  output logic [ID_W-1:0]  run_sender
);
  localparam int SKIP_W = $clog2(SKIP_LEN + 1);

  phase_t            phase;
  logic              armed;
  logic              page;
  logic [IDX_W-1:0]  idx;
  logic [COL_W-1:0]  col;
  logic [SKIP_W-1:0] skip;
  logic              take;

  assign smp_ready = armed && (phase == PH_TAKE || phase == PH_DROP);
  assign take      = smp_valid && smp_ready;
  assign acc_add   = take && (phase == PH_TAKE);
  assign acc_clr   = (phase == PH_WRITE);
  assign buf_we    = (phase == PH_WRITE);
  assign buf_waddr = {page, idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      armed      <= 1'b0;
      page       <= 1'b0;
      idx        <= '0;
      col        <= COL_W'(COL_FIRST);
      skip       <= '0;
      run        <= 1'b0;
      run_page   <= 1'b0;
      run_col    <= '0;
      run_sender <= '0;
    end else begin
      run <= 1'b0;
      if (take)            armed <= 1'b0;
      else if (!smp_valid) armed <= 1'b1;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_TAKE;
          idx   <= '0;
          col   <= COL_W'(COL_FIRST);
          skip  <= '0;
        end
        PH_TAKE: if (take && bin_last) phase <= PH_WRITE;
        PH_WRITE: begin
          if (idx == '1) begin
            run        <= 1'b1;
            run_page   <= page;
            run_col    <= col;
            run_sender <= sender;
            page       <= ~page;
            idx        <= '0;
            if (col == COL_W'(COL_LAST)) begin
              phase <= PH_DROP;
              skip  <= '0;
            end else begin
              col   <= col + 1'b1;
              phase <= PH_TAKE;
            end
          end else begin
            idx   <= idx + 1'b1;
            phase <= PH_TAKE;
          end
        end
        PH_DROP: if (take) begin
          if (skip == SKIP_W'(SKIP_LEN - 1)) phase <= PH_IDLE;
          else                               skip  <= skip + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spec_bin_scaler.sv
module spec_bin_scaler #(
  parameter int SAMPLE_W      = 17,
  parameter int ID_W          = 2,
  parameter int BIN_LEN       = 6,
  parameter int BINS_PER_PAGE = 8,
  parameter int HEIGHT_W      = 8,
  parameter int HEIGHT_MAX    = 72,
  parameter int TRUNC_LSB     = 15,
  parameter int COL_FIRST     = 2,
  parameter int COL_LAST      = 22,
  parameter int SKIP_LEN      = 16,
  localparam int SUM_W  = SAMPLE_W + $clog2(BIN_LEN),
  localparam int IDX_W  = $clog2(BINS_PER_PAGE),
  localparam int ADDR_W = IDX_W + 1,
  localparam int COL_W  = $clog2(COL_LAST + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [ID_W-1:0]     smp_sender,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [HEIGHT_W-1:0] rd_data,
  output logic                run,
  output logic                run_page,
  output logic [COL_W-1:0]    run_col,
  output logic [ID_W-1:0]     run_sender
);
  logic [SUM_W-1:0]    bin_sum;
  logic [ID_W-1:0]     bin_sender;
  logic                bin_last;
  logic                acc_add;
  logic                acc_clr;
  logic                buf_we;
  logic [ADDR_W-1:0]   buf_waddr;
  logic [HEIGHT_W-1:0] buf_wdata;

  sbas_frame_ctrl #(
    .IDX_W(IDX_W), .ID_W(ID_W), .COL_W(COL_W),
    .COL_FIRST(COL_FIRST), .COL_LAST(COL_LAST), .SKIP_LEN(SKIP_LEN)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .smp_valid(smp_valid), .smp_ready(smp_ready),
    .bin_last(bin_last), .sender(bin_sender),
    .acc_add(acc_add), .acc_clr(acc_clr),
    .buf_we(buf_we), .buf_waddr(buf_waddr),
    .run(run), .run_page(run_page), .run_col(run_col), .run_sender(run_sender)
  );

  sbas_bin_acc #(
    .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .ID_W(ID_W), .BIN_LEN(BIN_LEN)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .add_en(acc_add), .clr(acc_clr),
    .smp(smp_data), .smp_id(smp_sender),
    .sum(bin_sum), .sender(bin_sender), .bin_last(bin_last)
  );

  sbas_height_scale #(
    .SUM_W(SUM_W), .TRUNC_LSB(TRUNC_LSB),
    .HEIGHT_W(HEIGHT_W), .HEIGHT_MAX(HEIGHT_MAX)
  ) u_scale (
    .sum(bin_sum), .height(buf_wdata)
  );

  sbas_page_buf #(
    .ADDR_W(ADDR_W), .DATA_W(HEIGHT_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(buf_we), .wr_addr(buf_waddr), .wr_data(buf_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/sbas_chk.sv
module sbas_chk #(
  parameter int IDX_W      = 3,
  parameter int COL_W      = 5,
  parameter int HEIGHT_W   = 8,
  parameter int HEIGHT_MAX = 72,
  parameter int COL_FIRST  = 2,
  parameter int COL_LAST   = 22
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic                smp_ready,
  input logic                run,
  input logic                run_page,
  input logic [COL_W-1:0]    run_col,
  input logic                buf_we,
  input logic [IDX_W:0]      buf_waddr,
  input logic [HEIGHT_W-1:0] buf_wdata
);
  // R3
  hold_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);

  // R7
  run_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> !run);

  // R8
  run_col_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (run_col >= COL_W'(COL_FIRST) && run_col <= COL_W'(COL_LAST)));

  // R5
  height_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (buf_wdata <= HEIGHT_W'(HEIGHT_MAX)));

  // R6
  run_after_page_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ($past(buf_we) && ($past(buf_waddr[IDX_W-1:0]) == '1)
             && (run_page == $past(buf_waddr[IDX_W]))));
endmodule

bind spec_bin_scaler sbas_chk #(
  .IDX_W(IDX_W), .COL_W(COL_W), .HEIGHT_W(HEIGHT_W),
  .HEIGHT_MAX(HEIGHT_MAX), .COL_FIRST(COL_FIRST), .COL_LAST(COL_LAST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .run(run), .run_page(run_page), .run_col(run_col),
  .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata)
);

// File: tb/tb_spec_bin_scaler.sv
module tb_spec_bin_scaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [16:0] smp_data = '0;
  logic [1:0]  smp_sender = '0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        run;
  logic        run_page;
  logic [4:0]  run_col;
  logic [1:0]  run_sender;

  spec_bin_scaler dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .smp_sender(smp_sender),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .run(run), .run_page(run_page), .run_col(run_col), .run_sender(run_sender)
  );

  always #10 clk = ~clk;

  // one page of uniform bins and their hand-worked heights
  localparam logic [16:0] TV_IN [8] = '{17'd0, 17'd1, 17'd5461, 17'd10923,
                                        17'd32768, 17'd65536, 17'd100000, 17'd131071};
  localparam logic [7:0]  TV_H  [8] = '{8'd0, 8'd0, 8'd2, 8'd6, 8'd18, 8'd36, 8'd54, 8'd71};

  int n_chk = 0;
  int n_fail = 0;
  int run_cnt = 0;
  int wide_cnt = 0;
  int hold_bad = 0;
  logic run_prev = 1'b0;
  logic lst_page;
  logic [4:0] lst_col;
  logic [1:0] lst_sender;

  always @(negedge clk) begin
    if (rst_n) begin
      if (run) begin
        run_cnt++;
        lst_page   = run_page;
        lst_col    = run_col;
        lst_sender = run_sender;
        if (run_prev) wide_cnt++;
      end
      run_prev = run;
    end
  end

  function automatic int exp_h(input int unsigned s);
    int unsigned t;
    t = (s * 3) >> 15;
    return (t > 72) ? 72 : int'(t);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic send(input logic [16:0] d, input logic [1:0] id);
    smp_data = d;
    smp_sender = id;
    smp_valid = 1'b1;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    if (smp_ready) hold_bad++;
    smp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v;
    int dv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", int'(smp_ready), 0);
    chk("R1 run", int'(run), 0);
    rd(4'd5, v);
    chk("R1 buffer entry", v, 0);

    // R2 idle ignores valid
    smp_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 ready while idle", int'(smp_ready), 0);
    smp_valid = 1'b0;
    @(negedge clk);
    pulse_start();

    // column 2: table of vectors, page 0
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 6; k++) send(TV_IN[i], 2'(i));
    repeat (2) @(negedge clk);
    chk("R7 pulse count col2", run_cnt, 1);
    chk("R7 run_page col2", int'(lst_page), 0);
    chk("R8 run_col first", int'(lst_col), 2);
    chk("R4 run_sender col2", int'(lst_sender), 3);
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), v);
      chk("R5 R6 table height", v, int'(TV_H[i]));
    end

    // columns 3..22: ramped bins, pages alternate
    for (int c = 3; c <= 22; c++) begin
      for (int i = 0; i < 8; i++)
        for (int k = 0; k < 6; k++) send(17'(c * 4000 + i * 700), 2'(c % 4));
      repeat (2) @(negedge clk);
      chk("R8 pulse count", run_cnt, c - 1);
      chk("R8 run_col", int'(lst_col), c);
      chk("R7 run_page alternates", int'(lst_page), (c - 2) % 2);
      chk("R4 run_sender", int'(lst_sender), c % 4);
      for (int i = 0; i < 8; i++) begin
        rd({1'((c - 2) % 2), 3'(i)}, v);
        chk("R6 page entry", v, exp_h(6 * (c * 4000 + i * 700)));
      end
    end

    // R9 discard window of 16 full-scale samples
    for (int k = 0; k < 16; k++) send(17'd131071, 2'd0);
    chk("R9 ready low after discard", int'(smp_ready), 0);
    smp_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 idle after discard", int'(smp_ready), 0);
    smp_valid = 1'b0;
    @(negedge clk);
    chk("R9 no pulse in discard", run_cnt, 21);
    for (int i = 0; i < 8; i++) begin
      rd({1'b0, 3'(i)}, v);
      chk("R9 buffer untouched", v, exp_h(6 * (22 * 4000 + i * 700)));
    end

    // frame 2: non-uniform first bin, page bit carried over
    pulse_start();
    for (int k = 1; k <= 6; k++) send(17'(k * 10000), 2'(k % 4));
    for (int i = 1; i < 8; i++)
      for (int k = 0; k < 6; k++)
        send(17'd50000, (i == 7 && k == 5) ? 2'd2 : 2'd1);
    repeat (2) @(negedge clk);
    chk("R7 pulse frame2", run_cnt, 22);
    chk("R7 page carries over", int'(lst_page), 1);
    chk("R2 R8 column restarts", int'(lst_col), 2);
    chk("R4 last sender latched", int'(lst_sender), 2);
    rd(4'd8, v);
    chk("R10 mixed bin after clear", v, exp_h(210000));
    rd(4'd11, dv);
    chk("R10 uniform bin", dv, exp_h(300000));

    chk("R3 ready low after transfer", hold_bad, 0);
    chk("R7 run one cycle", wide_cnt, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule